// File: doc/BRIEF.md
# Flash Protected Range Checker

This block sits in front of a serial flash sequencer and decides, before any cycle starts, whether a requested flash access may proceed. It holds six protection ranges. Each range names a first and a last 4 KB page and carries two independent enables: one guarding reads, one guarding writes and erases. The sixth range acts as a global range and is checked in exactly the same way as the other five.

Requests arrive on a valid/ready stream: an access kind, a byte address and a byte count. The checker compares the span of bytes the access would touch against every enabled range in the same cycle the request is accepted, and registers the verdict with the request. In the next cycle a permitted request is offered to the sequencer on a second valid/ready stream. A refused request is never offered. Instead, the access-error flag pulses for that one cycle. An upstream source may hold a request valid for as long as it likes. The checker takes it only while `req_ready` is high. The sequencer applies back-pressure by holding `go_ready` low, and the offered request then stays frozen.

The range registers are written through a simple write port and read back through an index and data pair. A lock input freezes them until the next reset.

Top module: `prc_checker_top`

## Requirements
- R1: While `rst_n` is low and right after it is released, all six ranges read back as zero, the lock is clear, `go_valid` and `acc_err` are low and `req_ready` is high.
- R2: A cycle with `cfg_we` high stores `cfg_wdata` into the range selected by `cfg_idx`, and the new value is visible on `cfg_rdata` from the next cycle when `cfg_ridx` selects that range. Field layout: base page in bits 13:0, read-protect enable in bit 15, limit page in bits 29:16, write-protect enable in bit 31. Bits 14 and 30 always read as zero. An index of 6 or 7 is ignored on writes and reads back as zero.
- R3: A range covers the bytes from base×4096 through limit×4096+4095 inclusive. A range whose base page is above its limit page covers nothing. A range with neither enable set blocks nothing.
- R4: A read (`req_kind` 0) touches the bytes from `req_addr` through `req_addr`+`req_len`, because `req_len` is the byte count minus one. The read is refused if any of those bytes lies in a range with its read-protect enable set.
- R5: A write (`req_kind` 1) touches the same span as a read and is refused if any byte lies in a range with its write-protect enable set. The read-protect enable has no effect on writes.
- R6: A 4 KB erase (`req_kind` 2) touches the whole 4 KB-aligned block containing `req_addr`. A 64 KB erase (`req_kind` 3) touches the whole 64 KB-aligned block. Both are checked against write-protected ranges, and `req_len` is ignored.
- R7: A refused request raises `acc_err` for exactly the one cycle after its acceptance and never appears on the `go_*` outputs.
- R8: A permitted request appears with `go_valid` high in the cycle after its acceptance, carrying the same kind, address and length. It stays stable until a cycle with `go_ready` high.
- R9: `req_ready` is high when the stage is empty, holds a refused request, or is being drained by `go_ready`. Otherwise it is low. A request and a drain can complete in the same cycle.
- R10: In any cycle where `lock_i` is high, and in every later cycle until reset, writes to the ranges are ignored. The ranges keep blocking as before.
- R11: The last range (index 5) is the global range and blocks reads and writes under the same rules as the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Freezes the range registers until reset |
| cfg_we | input | 1 | Range register write strobe |
| cfg_idx | input | 3 | Range index to write |
| cfg_wdata | input | 32 | Range register write value |
| cfg_ridx | input | 3 | Range index to read back |
| cfg_rdata | output | 32 | Read-back value of the selected range |
| req_valid | input | 1 | Incoming access request valid |
| req_ready | output | 1 | Checker can take a request |
| req_kind | input | 2 | 0 read, 1 write, 2 erase 4 KB, 3 erase 64 KB |
| req_addr | input | 26 | Byte address of the access |
| req_len | input | 6 | Byte count minus one (reads and writes) |
| go_valid | output | 1 | Permitted request offered to the sequencer |
| go_ready | input | 1 | Sequencer takes the offered request |
| go_kind | output | 2 | Kind of the offered request |
| go_addr | output | 26 | Address of the offered request |
| go_len | output | 6 | Length of the offered request |
| acc_err | output | 1 | One-cycle pulse for a refused request |

## Verification
Several properties are checked on every cycle:
- `acc_err` and `go_valid` are never high together.
- Every accepted request produces exactly one of them on the next cycle.
- A stalled offer keeps its payload and holds `req_ready` low.
- Once locked, the range fields never change.

Whether a given span is refused depends on the exact byte arithmetic at range edges: inclusive limits, a span that straddles a page boundary, erase block alignment, empty ranges with base above limit, and read-only versus write-only ranges. Only the bench's scenarios can show this, with a behavioural model that predicts every output on every clock.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int PAGE_W  = 14;
  localparam int PAGE_SH = 12;
  localparam int BLK_SH  = 16;
  localparam int ADDR_W  = PAGE_W + PAGE_SH;
  localparam int EXT_W   = ADDR_W + 1;
  localparam int LEN_W   = 6;
  localparam int RNG_W   = 32;

  typedef enum logic [1:0] {
    ACC_READ      = 2'd0,
    ACC_WRITE     = 2'd1,
    ACC_ERASE_4K  = 2'd2,
    ACC_ERASE_64K = 2'd3
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e          kind;
    logic [ADDR_W-1:0]  addr;
    logic [LEN_W-1:0]   len;
  } acc_req_t;
endpackage

// File: rtl/prc_range_regs.sv
module prc_range_regs
  import prc_pkg::*;
#(
  parameter int NUM_RNG = 6,
  parameter int IDX_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            lock_i,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [RNG_W-1:0]                wr_data,
  input  logic [IDX_W-1:0]                rd_idx,
  output logic [RNG_W-1:0]                rd_data,
  output logic                            locked_o,
  output logic [NUM_RNG-1:0][PAGE_W-1:0]  base_o,
  output logic [NUM_RNG-1:0][PAGE_W-1:0]  lim_o,
  output logic [NUM_RNG-1:0]              rd_prot_o,
  output logic [NUM_RNG-1:0]              wr_prot_o
);
  logic frozen;
  logic rsvd_unused;

  assign frozen      = locked_o | lock_i;
  assign rsvd_unused = ^{wr_data[30], wr_data[14]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      locked_o <= 1'b0;
    else if (lock_i) locked_o <= 1'b1;
  end

  for (genvar g = 0; g < NUM_RNG; g++) begin : g_rng
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_o[g]    <= '0;
        lim_o[g]     <= '0;
        rd_prot_o[g] <= 1'b0;
        wr_prot_o[g] <= 1'b0;
      end else if (wr_en && !frozen && (wr_idx == IDX_W'(g))) begin
        base_o[g]    <= wr_data[PAGE_W-1:0];
        lim_o[g]     <= wr_data[16 +: PAGE_W];
        rd_prot_o[g] <= wr_data[15];
        wr_prot_o[g] <= wr_data[31];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_RNG; i++) begin
      if (rd_idx == IDX_W'(i))
        rd_data = {wr_prot_o[i], 1'b0, lim_o[i], rd_prot_o[i], 1'b0, base_o[i]};
    end
  end
endmodule

// File: rtl/prc_span_calc.sv
module prc_span_calc
  import prc_pkg::*;
(
  input  acc_kind_e          kind,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [LEN_W-1:0]   len,
  output logic [EXT_W-1:0]   lo,
  output logic [EXT_W-1:0]   hi,
  output logic               need_wr
);
  always_comb begin
    unique case (kind)
      ACC_ERASE_4K: begin
        lo = {1'b0, addr[ADDR_W-1:PAGE_SH], {PAGE_SH{1'b0}}};
        hi = {1'b0, addr[ADDR_W-1:PAGE_SH], {PAGE_SH{1'b1}}};
      end
      ACC_ERASE_64K: begin
        lo = {1'b0, addr[ADDR_W-1:BLK_SH], {BLK_SH{1'b0}}};
        hi = {1'b0, addr[ADDR_W-1:BLK_SH], {BLK_SH{1'b1}}};
      end
      default: begin
        lo = {1'b0, addr};
        hi = {1'b0, addr} + EXT_W'(len);
      end
    endcase
  end

  assign need_wr = (kind != ACC_READ);
endmodule

// File: rtl/prc_range_match.sv
module prc_range_match
  import prc_pkg::*;
#(
  parameter int NUM_RNG = 6
) (
  input  logic [NUM_RNG-1:0][PAGE_W-1:0]  base_i,
  input  logic [NUM_RNG-1:0][PAGE_W-1:0]  lim_i,
  input  logic [NUM_RNG-1:0]              rd_prot_i,
  input  logic [NUM_RNG-1:0]              wr_prot_i,
  input  logic [EXT_W-1:0]                lo_i,
  input  logic [EXT_W-1:0]                hi_i,
  input  logic                            need_wr_i,
  output logic                            blocked_o
);
  logic [NUM_RNG-1:0] hit;

  for (genvar g = 0; g < NUM_RNG; g++) begin : g_cmp
    logic [EXT_W-1:0] r_lo;
    logic [EXT_W-1:0] r_hi;
    logic             en;
    assign r_lo   = {1'b0, base_i[g], {PAGE_SH{1'b0}}};
    assign r_hi   = {1'b0, lim_i[g],  {PAGE_SH{1'b1}}};
    assign en     = need_wr_i ? wr_prot_i[g] : rd_prot_i[g];
    assign hit[g] = en && (base_i[g] <= lim_i[g]) && (lo_i <= r_hi) && (hi_i >= r_lo);
  end

  assign blocked_o = |hit;
endmodule

// File: rtl/prc_checker_top.sv
module prc_checker_top
  import prc_pkg::*;
#(
  parameter  int NUM_RNG = 6,
  localparam int IDX_W   = $clog2(NUM_RNG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [RNG_W-1:0]  cfg_wdata,
  input  logic [IDX_W-1:0]  cfg_ridx,
  output logic [RNG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              go_valid,
  input  logic              go_ready,
  output logic [1:0]        go_kind,
  output logic [ADDR_W-1:0] go_addr,
  output logic [LEN_W-1:0]  go_len,
  output logic              acc_err
);
  logic [NUM_RNG-1:0][PAGE_W-1:0] rng_base;
  logic [NUM_RNG-1:0][PAGE_W-1:0] rng_lim;
  logic [NUM_RNG-1:0]             rng_rd;
  logic [NUM_RNG-1:0]             rng_wr;
  logic                           locked_q;

  acc_req_t         req_in;
  acc_req_t         stg_q;
  logic             stg_v;
  logic             stg_blk;
  logic [EXT_W-1:0] span_lo;
  logic [EXT_W-1:0] span_hi;
  logic             need_wr;
  logic             blocked;
  logic             accept;
  logic             drain;

  prc_range_regs #(.NUM_RNG(NUM_RNG), .IDX_W(IDX_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_i    (lock_i),
    .wr_en     (cfg_we),
    .wr_idx    (cfg_idx),
    .wr_data   (cfg_wdata),
    .rd_idx    (cfg_ridx),
    .rd_data   (cfg_rdata),
    .locked_o  (locked_q),
    .base_o    (rng_base),
    .lim_o     (rng_lim),
    .rd_prot_o (rng_rd),
    .wr_prot_o (rng_wr)
  );

  assign req_in = '{kind: acc_kind_e'(req_kind), addr: req_addr, len: req_len};

  prc_span_calc span_i (
    .kind    (req_in.kind),
    .addr    (req_in.addr),
    .len     (req_in.len),
    .lo      (span_lo),
    .hi      (span_hi),
    .need_wr (need_wr)
  );

  prc_range_match #(.NUM_RNG(NUM_RNG)) match_i (
    .base_i    (rng_base),
    .lim_i     (rng_lim),
    .rd_prot_i (rng_rd),
    .wr_prot_i (rng_wr),
    .lo_i      (span_lo),
    .hi_i      (span_hi),
    .need_wr_i (need_wr),
    .blocked_o (blocked)
  );

  assign drain     = stg_v && (stg_blk || go_ready);
  assign req_ready = !stg_v || drain;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v   <= 1'b0;
      stg_blk <= 1'b0;
      stg_q   <= '0;
    end else if (accept) begin
      stg_v   <= 1'b1;
      stg_blk <= blocked;
      stg_q   <= req_in;
    end else if (drain) begin
      stg_v   <= 1'b0;
      stg_blk <= 1'b0;
    end
  end

  assign go_valid = stg_v && !stg_blk;
  assign acc_err  = stg_v && stg_blk;
  assign go_kind  = stg_q.kind;
  assign go_addr  = stg_q.addr;
  assign go_len   = stg_q.len;
endmodule

// File: rtl/prc_checker_sva.sv
module prc_checker_sva
  import prc_pkg::*;
#(
  parameter int NUM_RNG = 6
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           req_valid,
  input logic                           req_ready,
  input logic                           go_valid,
  input logic                           go_ready,
  input logic [1:0]                     go_kind,
  input logic [ADDR_W-1:0]              go_addr,
  input logic [LEN_W-1:0]               go_len,
  input logic                           acc_err,
  input logic                           locked,
  input logic [NUM_RNG-1:0][PAGE_W-1:0] rng_base,
  input logic [NUM_RNG-1:0][PAGE_W-1:0] rng_lim,
  input logic [NUM_RNG-1:0]             rng_rd,
  input logic [NUM_RNG-1:0]             rng_wr
);
  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> !go_valid);

  // R8
  go_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_valid && !go_ready |=> go_valid && $stable(go_kind) && $stable(go_addr) && $stable(go_len));

  // R8
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> go_valid || acc_err);

  // R9
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_valid && !go_ready |-> !req_ready);

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && $stable(rng_base) && $stable(rng_lim) && $stable(rng_rd) && $stable(rng_wr));
endmodule

bind prc_checker_top prc_checker_sva #(.NUM_RNG(NUM_RNG)) sva_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .go_valid  (go_valid),
  .go_ready  (go_ready),
  .go_kind   (go_kind),
  .go_addr   (go_addr),
  .go_len    (go_len),
  .acc_err   (acc_err),
  .locked    (locked_q),
  .rng_base  (rng_base),
  .rng_lim   (rng_lim),
  .rng_rd    (rng_rd),
  .rng_wr    (rng_wr)
);

// File: tb/prc_checker_top_tb_top.sv
`timescale 1ns/1ps
module prc_checker_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock_i = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  cfg_ridx = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [25:0] req_addr = '0;
  logic [5:0]  req_len = '0;
  logic        go_valid;
  logic        go_ready = 1'b1;
  logic [1:0]  go_kind;
  logic [25:0] go_addr;
  logic [5:0]  go_len;
  logic        acc_err;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  prc_checker_top dut_i (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len),
    .go_valid(go_valid), .go_ready(go_ready), .go_kind(go_kind),
    .go_addr(go_addr), .go_len(go_len), .acc_err(acc_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_rng [6];
  bit          m_locked, m_v, m_blk;
  logic [1:0]  m_kind;
  logic [25:0] m_addr;
  logic [5:0]  m_len;

  function automatic bit m_blocked(input logic [1:0] k, input logic [25:0] a, input logic [5:0] n);
    longint lo, hi, rlo, rhi;
    if (k == 2)      begin lo = (longint'(a) / 4096) * 4096;   hi = lo + 4095;  end
    else if (k == 3) begin lo = (longint'(a) / 65536) * 65536; hi = lo + 65535; end
    else             begin lo = longint'(a); hi = lo + longint'(n); end
    for (int i = 0; i < 6; i++) begin
      bit en;
      en  = (k == 0) ? m_rng[i][15] : m_rng[i][31];
      rlo = longint'(m_rng[i][13:0]) * 4096;
      rhi = longint'(m_rng[i][29:16]) * 4096 + 4095;
      if (en && rlo <= rhi && lo <= rhi && hi >= rlo) return 1'b1;
    end
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) m_rng[i] = '0;
      m_locked = 0; m_v = 0; m_blk = 0;
      m_kind = '0; m_addr = '0; m_len = '0;
    end else begin
      bit rdy;
      rdy = !m_v || m_blk || go_ready;
      if (req_valid && rdy) begin
        m_v = 1; m_blk = m_blocked(req_kind, req_addr, req_len);
        m_kind = req_kind; m_addr = req_addr; m_len = req_len;
      end else if (m_v && (m_blk || go_ready)) begin
        m_v = 0; m_blk = 0;
      end
      if (cfg_we && !(m_locked || lock_i) && cfg_idx < 6)
        m_rng[cfg_idx] = cfg_wdata & 32'hBFFF_BFFF;
      if (lock_i) m_locked = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] exp_rd;
      exp_rd = (cfg_ridx < 6) ? m_rng[cfg_ridx] : 32'h0;
      chk(go_valid === (m_v && !m_blk), "R8 go_valid", 64'(go_valid), 64'(m_v && !m_blk));
      chk(acc_err === (m_v && m_blk), "R7 acc_err", 64'(acc_err), 64'(m_v && m_blk));
      chk(req_ready === (!m_v || m_blk || go_ready), "R9 req_ready", 64'(req_ready), 64'(!m_v || m_blk || go_ready));
      if (m_v && !m_blk)
        chk({go_kind, go_addr, go_len} === {m_kind, m_addr, m_len}, "R8 payload",
            64'({go_kind, go_addr, go_len}), 64'({m_kind, m_addr, m_len}));
      chk(cfg_rdata === exp_rd, "R2 readback", 64'(cfg_rdata), 64'(exp_rd));
    end
  end

  function automatic logic [31:0] rng(input logic [13:0] b, input logic [13:0] l, input bit rd, input bit wr);
    return {wr, 1'b0, l, rd, 1'b0, b};
  endfunction

  task automatic cfg(input int idx, input logic [31:0] v);
    @(posedge clk); #1;
    cfg_we = 1; cfg_idx = 3'(idx); cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic rdback(input int idx, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    cfg_ridx = 3'(idx);
    @(negedge clk);
    chk(cfg_rdata === exp, tag, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic send(input logic [1:0] k, input logic [25:0] a, input logic [5:0] n,
                      input bit exp_blk, input string tag);
    @(posedge clk); #1;
    req_valid = 1; req_kind = k; req_addr = a; req_len = n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk(acc_err === exp_blk, tag, 64'(acc_err), 64'(exp_blk));
    chk(go_valid === (go_ready ? !exp_blk : !exp_blk), tag, 64'(go_valid), 64'(!exp_blk));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk(go_valid === 0 && acc_err === 0, "R1 outputs idle", 64'({go_valid, acc_err}), 64'(0));
    chk(req_ready === 1, "R1 ready", 64'(req_ready), 64'(1));
    chk(cfg_rdata === 0, "R1 range zero", 64'(cfg_rdata), 64'(0));

    // R2 programming and readback, reserved bits read zero
    cfg(0, rng(14'h010, 14'h01F, 1, 0));
    cfg(1, rng(14'h040, 14'h040, 0, 1));
    cfg(2, rng(14'h000, 14'h3FFF, 0, 0) | 32'h4000_4000);
    cfg(3, rng(14'h301, 14'h300, 1, 0));
    cfg(5, rng(14'h100, 14'h1FF, 1, 1));
    cfg(6, 32'hFFFF_FFFF);
    rdback(0, rng(14'h010, 14'h01F, 1, 0), "R2 range0");
    rdback(2, rng(14'h000, 14'h3FFF, 0, 0), "R2 reserved bits");
    rdback(6, 32'h0, "R2 out-of-range index");

    // R4 read span edges
    send(0, 26'h000FFFC, 6'd3, 0, "R4 read below range");
    send(0, 26'h000FFFC, 6'd4, 1, "R4 read straddles base");
    send(0, 26'h001FFFF, 6'd0, 1, "R3 limit inclusive");
    send(0, 26'h0020000, 6'd63, 0, "R3 past limit");
    send(0, 26'h0300FFF, 6'd1, 0, "R3 base above limit empty");
    // R5 writes
    send(1, 26'h0018000, 6'd15, 0, "R5 read-only range lets writes");
    send(1, 26'h003FFF0, 6'd15, 0, "R5 write below range");
    send(1, 26'h003FFF1, 6'd15, 1, "R5 write straddles base");
    send(0, 26'h0040800, 6'd63, 0, "R5 write-only range lets reads");
    // R6 erases
    send(2, 26'h0040ABC, 6'd0, 1, "R6 erase4k inside");
    send(2, 26'h0041000, 6'd63, 0, "R6 erase4k next block");
    send(2, 26'h003F123, 6'd0, 0, "R6 erase4k prev block");
    send(3, 26'h004F000, 6'd0, 1, "R6 erase64k covers range");
    send(3, 26'h0030000, 6'd0, 0, "R6 erase64k below");
    send(3, 26'h001F000, 6'd0, 0, "R6 erase64k on read-only range");
    // R11 global range
    send(0, 26'h0180000, 6'd0, 1, "R11 global read");
    send(1, 26'h01FFFFF, 6'd0, 1, "R11 global write limit");
    send(1, 26'h0200000, 6'd0, 0, "R11 global past limit");

    // R7 back-to-back refused requests
    @(posedge clk); #1;
    req_valid = 1; req_kind = 0; req_addr = 26'h0010000; req_len = 0;
    @(negedge clk);
    @(posedge clk); #1;
    @(negedge clk);
    chk(acc_err === 1, "R7 first refusal", 64'(acc_err), 64'(1));
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk(acc_err === 1, "R7 second refusal", 64'(acc_err), 64'(1));
    @(negedge clk);
    chk(acc_err === 0, "R7 single cycle", 64'(acc_err), 64'(0));

    // R8 / R9 back-pressure
    @(posedge clk); #1 go_ready = 0;
    send(0, 26'h0020000, 6'd7, 0, "R8 offered");
    @(posedge clk); #1;
    req_valid = 1; req_kind = 1; req_addr = 26'h0050000; req_len = 6'd3;
    repeat (3) @(negedge clk);
    chk(go_valid === 1 && go_addr === 26'h0020000, "R8 held under stall", 64'(go_addr), 64'h20000);
    chk(req_ready === 0, "R9 not ready under stall", 64'(req_ready), 64'(0));
    @(posedge clk); #1 go_ready = 1;
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    chk(go_valid === 1 && go_addr === 26'h0050000, "R9 drain and accept same cycle", 64'(go_addr), 64'h50000);
    @(negedge clk);

    // R10 lock
    @(posedge clk); #1 lock_i = 1;
    @(posedge clk); #1 lock_i = 0;
    cfg(0, 32'h0);
    rdback(0, rng(14'h010, 14'h01F, 1, 0), "R10 write ignored");
    send(0, 26'h0010000, 6'd0, 1, "R10 still blocks");

    // R1 / R10 reset clears ranges and lock
    @(posedge clk); #1 rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    rdback(0, 32'h0, "R1 range cleared");
    send(0, 26'h0010000, 6'd0, 0, "R1 no ranges after reset");
    cfg(0, rng(14'h010, 14'h01F, 1, 0));
    rdback(0, rng(14'h010, 14'h01F, 1, 0), "R10 unlocked by reset");

    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule